// File: doc/BRIEF.md
# Pipelined Interrupt Message Controller

This block collects interrupt events for a bank of bidirectional 24 V lines and holds them in message registers that a host reads over a bus. Three kinds of event are collected: a level change on any line working as an input, a new overcurrent on any line working as an output, and the onset of either of two over-temperature levels. The lines come in equal groups, and each group is switched as a whole between input and output mode. Per-line enable vectors decide which line events are kept. The temperature events cannot be masked. An active-low interrupt line is asserted while any message is held.

The message registers are protected while the host is handling them. A read strobe for a message register freezes that register. Events that arrive while it is frozen are merged into a hidden one-deep stage, so no event is lost. An end-of-interrupt pulse then either empties everything and releases the interrupt line, or moves the hidden stage into view and keeps the line asserted. Bus decoding, register storage for the enables and the timing of the overcurrent filters belong to the surrounding logic.

Top module: `intmsg_ctrl`

## Requirements
- R1: For a line in input mode whose change enable is 1, a rising or a falling edge of its level sets the matching bit of `chg_msg` on the clock edge that samples the new level.
- R2: An edge on a line whose change enable is 0 sets no bit of `chg_msg`.
- R3: For a line in output mode whose overcurrent enable is 1, a 0-to-1 step of its overcurrent status sets the matching bit of `oc_msg`.
- R4: A 0-to-1 step of `temp1_hot` or `temp2_hot` is always stored, as status bit 5 or status bit 6, whatever the enables are.
- R5: `status` bit 7 is 1 when any `chg_msg` bit is set and bit 4 when any `oc_msg` bit is set. Bits 2 and 1 follow the live level-2 and level-1 temperature inputs. Bit 0 is the OR of the live overcurrent inputs of lines in output mode. Bit 3 reads 0.
- R6: `int_n` is 0 exactly while a visible or a pipelined message exists.
- R7: After a read strobe for a message register, no new bit appears in that register until end-of-interrupt or a mode change.
- R8: An event that arrives while its register is frozen is held in the pipeline stage, and it drives `int_n` low even when the visible register is empty.
- R9: End-of-interrupt with an empty pipeline clears every visible message, unfreezes the registers and releases `int_n`.
- R10: End-of-interrupt with a non-empty pipeline moves the pipeline into the visible registers, and `int_n` stays 0.
- R11: While a line's enable is 0, its visible and pipelined message bits are cleared. A pending message is therefore removed by clearing the enable and then setting it again.
- R12: Any change of `grp_out` clears all messages, visible and pipelined.
- R13: `chg_msg` bits of lines in output mode and `oc_msg` bits of lines in input mode read 0. Line i belongs to group i/4 with the default parameters, and `grp_out` bit 1 puts a group in output mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| grp_out | input | 2 | Per-group mode, 1 = output |
| line_lvl | input | 8 | Filtered level of each line |
| oc_live | input | 8 | Live overcurrent status per line |
| temp1_hot | input | 1 | Temperature level 1 (warning) live |
| temp2_hot | input | 1 | Temperature level 2 (shutdown) live |
| chg_en | input | 8 | Change-of-input message enables |
| oc_en | input | 8 | Overcurrent message enables |
| rd_chg | input | 1 | Read strobe, change-of-input register |
| rd_oc | input | 1 | Read strobe, overcurrent register |
| rd_stat | input | 1 | Read strobe, status register |
| eoi | input | 1 | End-of-interrupt pulse |
| chg_msg | output | 8 | Change-of-input message register |
| oc_msg | output | 8 | Overcurrent message register |
| status | output | 8 | Status: stored flags high, live levels low |
| int_n | output | 1 | Interrupt request, active low |

## Verification
The assertions assume that the read strobes and the end-of-interrupt input are single-cycle pulses, and that all inputs change only between clock edges. They also assume that the line, overcurrent and temperature inputs are already filtered and free of glitches. The bench drives every input on the falling edge and holds it for at least one full cycle. It raises each strobe for exactly one cycle. It changes `grp_out` only at points where stale messages are expected to be wiped.

// File: rtl/intmsg_pkg.sv
package intmsg_pkg;

    // Bit layout of the status register; the host decodes these positions.
    localparam int ST_CHG_FLAG = 7;
    localparam int ST_T2_FLAG  = 6;
    localparam int ST_T1_FLAG  = 5;
    localparam int ST_OC_FLAG  = 4;
    localparam int ST_T2_LIVE  = 2;
    localparam int ST_T1_LIVE  = 1;
    localparam int ST_OC_LIVE  = 0;

    typedef struct packed {
        logic chg_flag;
        logic t2_flag;
        logic t1_flag;
        logic oc_flag;
        logic spare;
        logic t2_live;
        logic t1_live;
        logic oc_any;
    } stat_t;

    // Group that owns a given line.
    function automatic int group_of(input int line, input int lines_per_group);
        return line / lines_per_group;
    endfunction

endpackage

// File: rtl/intmsg_edge.sv
module intmsg_edge #(
    parameter int W         = 8,
    parameter bit RISE_ONLY = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         primed,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] evt
);
    logic [W-1:0] prev_q;
    logic [W-1:0] raw;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    generate
        if (RISE_ONLY) begin : g_rise
            assign raw = lvl & ~prev_q;
        end else begin : g_both
            assign raw = lvl ^ prev_q;
        end
    endgenerate

    // No events on the first cycle out of reset, before prev_q holds a real level.
    assign evt = primed ? raw : '0;
endmodule

// File: rtl/intmsg_stage.sv
module intmsg_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         eoi,
    input  logic         rd,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] keep,
    output logic [W-1:0] vis,
    output logic [W-1:0] pipe
);
    logic frz;

    always_ff @(posedge clk) begin
        if (rst || clr)  frz <= 1'b0;
        else if (eoi)    frz <= 1'b0;
        else if (rd)     frz <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            vis  <= '0;
            pipe <= '0;
        end else if (eoi) begin
            vis  <= (pipe | evt) & keep;
            pipe <= '0;
        end else if (frz) begin
            vis  <= vis & keep;
            pipe <= (pipe | evt) & keep;
        end else begin
            vis  <= (vis | evt) & keep;
            pipe <= pipe & keep;
        end
    end

    assert_frozen_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (frz && !eoi && !clr) |=> ((vis & ~$past(vis)) == '0));

    assert_pipe_only_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        (!frz && !eoi) |=> ((pipe & ~$past(pipe)) == '0));

    assert_eoi_release_R9: assert property (@(posedge clk) disable iff (rst)
        (eoi && !clr && pipe == '0 && (evt & keep) == '0) |=> (vis == '0 && !frz));

    assert_mask_clears_R11: assert property (@(posedge clk) disable iff (rst)
        (keep != '1) |=> (((vis | pipe) & ~$past(keep)) == '0));
endmodule

// File: rtl/intmsg_ctrl.sv
module intmsg_ctrl
    import intmsg_pkg::*;
#(
    parameter int NUM_LINES  = 8,
    parameter int NUM_GROUPS = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_GROUPS-1:0] grp_out,
    input  logic [NUM_LINES-1:0]  line_lvl,
    input  logic [NUM_LINES-1:0]  oc_live,
    input  logic                  temp1_hot,
    input  logic                  temp2_hot,
    input  logic [NUM_LINES-1:0]  chg_en,
    input  logic [NUM_LINES-1:0]  oc_en,
    input  logic                  rd_chg,
    input  logic                  rd_oc,
    input  logic                  rd_stat,
    input  logic                  eoi,
    output logic [NUM_LINES-1:0]  chg_msg,
    output logic [NUM_LINES-1:0]  oc_msg,
    output logic [7:0]            status,
    output logic                  int_n
);
    localparam int LPG = NUM_LINES / NUM_GROUPS;

    logic                  primed;
    logic [NUM_GROUPS-1:0] mode_prev;
    logic                  mode_chg;
    logic [NUM_LINES-1:0]  out_mask;
    logic [NUM_LINES-1:0]  chg_keep, oc_keep;
    logic [NUM_LINES-1:0]  chg_evt, oc_evt;
    logic [1:0]            temp_evt;
    logic [NUM_LINES-1:0]  chg_pipe, oc_pipe;
    logic [1:0]            temp_vis, temp_pipe;
    stat_t                 st;

    always_ff @(posedge clk) begin
        if (rst) begin
            primed    <= 1'b0;
            mode_prev <= '0;
        end else begin
            primed    <= 1'b1;
            mode_prev <= grp_out;
        end
    end

    assign mode_chg = primed && (grp_out != mode_prev);

    generate
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_mask
            assign out_mask[i] = grp_out[group_of(i, LPG)];
        end
    endgenerate

    assign chg_keep = chg_en & ~out_mask;
    assign oc_keep  = oc_en & out_mask;

    intmsg_edge #(.W(NUM_LINES), .RISE_ONLY(1'b0)) u_chg_edge (
        .clk(clk), .rst(rst), .primed(primed), .lvl(line_lvl), .evt(chg_evt));

    intmsg_edge #(.W(NUM_LINES), .RISE_ONLY(1'b1)) u_oc_edge (
        .clk(clk), .rst(rst), .primed(primed), .lvl(oc_live), .evt(oc_evt));

    intmsg_edge #(.W(2), .RISE_ONLY(1'b1)) u_temp_edge (
        .clk(clk), .rst(rst), .primed(primed), .lvl({temp2_hot, temp1_hot}), .evt(temp_evt));

    intmsg_stage #(.W(NUM_LINES)) u_chg_stage (
        .clk(clk), .rst(rst), .clr(mode_chg), .eoi(eoi), .rd(rd_chg),
        .evt(chg_evt), .keep(chg_keep), .vis(chg_msg), .pipe(chg_pipe));

    intmsg_stage #(.W(NUM_LINES)) u_oc_stage (
        .clk(clk), .rst(rst), .clr(mode_chg), .eoi(eoi), .rd(rd_oc),
        .evt(oc_evt), .keep(oc_keep), .vis(oc_msg), .pipe(oc_pipe));

    intmsg_stage #(.W(2)) u_temp_stage (
        .clk(clk), .rst(rst), .clr(mode_chg), .eoi(eoi), .rd(rd_stat),
        .evt(temp_evt), .keep(2'b11), .vis(temp_vis), .pipe(temp_pipe));

    always_comb begin
        st          = '0;
        st.chg_flag = |chg_msg;
        st.t2_flag  = temp_vis[1];
        st.t1_flag  = temp_vis[0];
        st.oc_flag  = |oc_msg;
        st.spare    = 1'b0;
        st.t2_live  = temp2_hot;
        st.t1_live  = temp1_hot;
        st.oc_any   = |(oc_live & out_mask);
    end

    assign status = st;
    assign int_n  = ~(|{chg_msg, oc_msg, temp_vis, chg_pipe, oc_pipe, temp_pipe});

    assert_mode_clear_R12: assert property (@(posedge clk) disable iff (rst)
        mode_chg |=> (chg_msg == '0 && oc_msg == '0 && int_n));

    assert_opposite_zero_R13: assert property (@(posedge clk) disable iff (rst)
        (grp_out == mode_prev) |=>
            ((chg_msg & $past(out_mask)) == '0 && (oc_msg & ~$past(out_mask)) == '0));
endmodule

// File: tb/intmsg_ctrl_test.sv
module intmsg_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] grp_out = '0;
    logic [7:0] line_lvl = '0, oc_live = '0, chg_en = '0, oc_en = '0;
    logic       temp1_hot = 1'b0, temp2_hot = 1'b0;
    logic       rd_chg = 1'b0, rd_oc = 1'b0, rd_stat = 1'b0, eoi = 1'b0;
    logic [7:0] chg_msg, oc_msg, status;
    logic       int_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    intmsg_ctrl uut (
        .clk(clk), .rst(rst), .grp_out(grp_out), .line_lvl(line_lvl), .oc_live(oc_live),
        .temp1_hot(temp1_hot), .temp2_hot(temp2_hot), .chg_en(chg_en), .oc_en(oc_en),
        .rd_chg(rd_chg), .rd_oc(rd_oc), .rd_stat(rd_stat), .eoi(eoi),
        .chg_msg(chg_msg), .oc_msg(oc_msg), .status(status), .int_n(int_n));

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic pulse_eoi();
        eoi = 1'b1; step(); eoi = 1'b0;
    endtask

    task automatic pulse_rd_chg();
        rd_chg = 1'b1; step(); rd_chg = 1'b0;
    endtask

    task automatic pulse_rd_stat();
        rd_stat = 1'b1; step(); rd_stat = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got 00 expected 01");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(); step();
        rst = 1'b0;
        step();
        // reset state
        chk("R6 reset int_n", {7'd0, int_n}, 8'h01);
        chk("R1 reset chg", chg_msg, 8'h00);
        chk("R3 reset oc", oc_msg, 8'h00);
        chk("R5 reset status", status, 8'h00);

        // R1 sweep: each line, rising then falling edge
        chg_en = 8'hFF;
        step();
        for (int i = 0; i < 8; i++) begin
            for (int e = 0; e < 2; e++) begin
                line_lvl[i] = ~line_lvl[i];
                step();
                chk("R1 edge latched", chg_msg, 8'(1 << i));
                chk("R6 int_n low", {7'd0, int_n}, 8'h00);
                chk("R5 chg flag", status, 8'h80);
                pulse_eoi();
                chk("R9 eoi clears", chg_msg, 8'h00);
                chk("R9 int_n released", {7'd0, int_n}, 8'h01);
            end
        end

        // R2: enable patterns
        for (int p = 0; p < 4; p++) begin
            logic [7:0] en;
            en = 8'(8'h11 << p) ^ 8'h0F;
            chg_en = en;
            step();
            line_lvl = ~line_lvl;
            step();
            chk("R2 masked edges", chg_msg, en);
            pulse_eoi();
        end
        chg_en = 8'h00;
        step();
        line_lvl = ~line_lvl;
        step();
        chk("R2 all disabled", chg_msg, 8'h00);
        chk("R2 int_n high", {7'd0, int_n}, 8'h01);

        // R12: mode change wipes pending messages
        chg_en = 8'hFF;
        step();
        line_lvl = ~line_lvl;
        step();
        chk("R1 all lines", chg_msg, 8'hFF);
        grp_out = 2'b10;
        step();
        chk("R12 mode clear chg", chg_msg, 8'h00);
        chk("R12 mode clear int_n", {7'd0, int_n}, 8'h01);

        // R13: upper group in output mode
        line_lvl = ~line_lvl;
        step();
        chk("R13 output lines read 0", chg_msg, 8'h0F);
        pulse_eoi();

        // R3 overcurrent, lower group input
        oc_en = 8'hFF;
        oc_live = 8'hFF;
        step();
        chk("R13 oc input lines 0", oc_msg, 8'hF0);
        chk("R5 oc flags", status, 8'h11);
        oc_live = 8'h00;
        step();
        chk("R5 live oc gone", status, 8'h10);
        pulse_eoi();
        for (int i = 4; i < 8; i++) begin
            oc_en = 8'(1 << i) | 8'h01;
            step();
            oc_live = 8'hFF;
            step();
            chk("R3 single enable", oc_msg, 8'(1 << i));
            oc_live = 8'h00;
            pulse_eoi();
        end
        oc_en = 8'h00;
        step();
        oc_live = 8'hF0;
        step();
        chk("R3 disabled no msg", oc_msg, 8'h00);
        chk("R5 live oc shown", status, 8'h01);
        oc_live = 8'h00;
        grp_out = 2'b00;
        step();

        // R4 temperature
        temp1_hot = 1'b1; step();
        chk("R4 temp1", status, 8'h22);
        temp1_hot = 1'b0; step();
        chk("R4 temp1 stored", status, 8'h20);
        pulse_eoi();
        temp2_hot = 1'b1; step();
        chk("R4 temp2", status, 8'h44);
        temp2_hot = 1'b0; step();
        pulse_eoi();
        chk("R9 temp cleared", status, 8'h00);

        // R7 / R8 / R10 on change register
        line_lvl[0] = ~line_lvl[0]; step();
        pulse_rd_chg();
        line_lvl[1] = ~line_lvl[1]; step();
        chk("R7 frozen", chg_msg, 8'h01);
        pulse_eoi();
        chk("R10 refill", chg_msg, 8'h02);
        chk("R10 int_n stays low", {7'd0, int_n}, 8'h00);
        pulse_eoi();
        chk("R9 release", {7'd0, int_n}, 8'h01);

        // R8 read of an empty register
        pulse_rd_chg();
        line_lvl[2] = ~line_lvl[2]; step();
        chk("R8 visible empty", chg_msg, 8'h00);
        chk("R8 int_n from pipeline", {7'd0, int_n}, 8'h00);
        pulse_eoi();
        chk("R10 pipeline shown", chg_msg, 8'h04);
        pulse_eoi();

        // R11: disable/enable removes pending bits
        line_lvl[3] = ~line_lvl[3]; step();
        pulse_rd_chg();
        line_lvl[4] = ~line_lvl[4]; step();
        chg_en = 8'hE7; step();
        chk("R11 visible removed", chg_msg, 8'h00);
        chg_en = 8'hFF; step();
        chk("R11 int_n released", {7'd0, int_n}, 8'h01);
        pulse_eoi();
        chk("R11 pipeline removed", chg_msg, 8'h00);

        // R7 on status register
        temp1_hot = 1'b1; step();
        pulse_rd_stat();
        temp2_hot = 1'b1; step();
        chk("R7 status frozen", status, 8'h26);
        temp1_hot = 1'b0; temp2_hot = 1'b0; step();
        pulse_eoi();
        chk("R10 status refill", status, 8'h40);
        pulse_eoi();
        chk("R9 status clear", status, 8'h00);
        chk("R6 final int_n", {7'd0, int_n}, 8'h01);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule